// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder

This block is the device-side control logic of a small synchronous DRAM with two banks. On every rising clock edge it samples the chip-select, row-strobe, column-strobe, write-enable, data-mask, clock-enable, bank-select and address pins. It turns them into a single registered command strobe and keeps an open/idle state for each bank. It also produces the timing of the read data-output enable and of the write data mask. The read enable follows the programmed CAS latency, and the data mask closes the outputs two clocks after it is sampled on reads but blocks the write in the same clock.

The clock-enable pin drives a four-state power machine with the states RUN, SUSPEND, POWER_DOWN and SELF_REFRESH. From RUN, a low clock-enable sample takes one of three transitions. The enter-self-refresh transition fires on a refresh command with all banks idle. The enter-power-down transition fires on a no-op or deselect with all banks idle. Every other case takes the enter-suspend transition. From any of the three frozen states, the wake transition back to RUN fires when clock-enable is sampled high. Commands are decoded only in RUN, so both entry and exit cost exactly one clock. In SUSPEND the read-latency pipe is frozen, so a read in flight is stretched. Each bank is a two-state machine, IDLE and OPEN, with an open transition (activate) and a close transition (precharge, precharge-all, or a read or write with auto-precharge). A command that is not legal for the current bank states is dropped and sets a sticky error flag.

Top module: `sdr_cmd_ctrl`

## Requirements
- R1: With chip-select low, {ras_n,cas_n,we_n} decodes as 000 mode set, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op, and chip-select high is deselect. addr[10] turns read/write into their auto-precharge forms and precharge into precharge-all. An accepted command raises one bit of `cmd_stb` for the cycle after its edge: bit 0 mode set, 1 refresh, 2 self refresh entry, 3 single precharge, 4 precharge all, 5 activate, 6 write, 7 write+AP, 8 read, 9 read+AP, 10 burst stop. No-op and deselect raise no bit, and at most one bit is ever high.
- R2: `bank_sel` 0 addresses bank 0 (`bank_active[0]`) and 1 addresses bank 1. Activate opens the addressed bank. Precharge, read+AP and write+AP close the addressed bank, and precharge-all closes both.
- R3: `wr_mask` is high in the cycle after an accepted write (either form) exactly when `dqm` was high at that same edge.
- R4: A read accepted at edge k with CAS latency CL raises `rd_oe` for the one cycle after edge k+CL-1. CL resets to 2 and is loaded from addr[5:4] by a mode set. A value of 0 or above 3 is illegal.
- R5: On reads, `dqm` high at edge j suppresses the `rd_oe` pulse that would follow edge j+1. A `dqm` high at any later edge has no effect on that pulse.
- R6: Clock-enable sampled low in RUN, when the edge is not a power-down or self-refresh entry, enters SUSPEND. In SUSPEND no command is accepted, bank states do not change and the read-latency pipe holds. A high clock-enable sample returns to RUN, and commands are accepted again from the following edge.
- R7: A no-op or deselect with clock-enable low and both banks idle enters POWER_DOWN and sets `pwr_down` from the next cycle. Commands are ignored while powered down and at the exit edge (clock-enable high). `pwr_down` clears after the exit edge.
- R8: A refresh with clock-enable high pulses bit 1. With clock-enable low it pulses bit 2 and enters SELF_REFRESH, which sets `pwr_down` until an edge with clock-enable high.
- R9: Activate of an open bank, read or write to an idle bank, and mode set or refresh while any bank is open are illegal. An illegal command sets `err`, raises no strobe and changes no state. `err` stays set until reset.
- R10: During and right after reset, `cmd_stb`, `bank_active`, `rd_oe`, `wr_mask`, `pwr_down` and `err` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dqm | input | 1 | Data mask / output disable |
| bank_sel | input | 1 | Bank select |
| addr | input | ADDR_W | Address bus (A10 auto-precharge, A5:A4 latency on mode set) |
| cmd_stb | output | 11 | One-hot accepted-command strobe |
| bank_active | output | 2 | Per-bank open flag |
| rd_oe | output | 1 | Read data output enable |
| wr_mask | output | 1 | Write data mask strobe |
| pwr_down | output | 1 | Power-down or self-refresh in effect |
| err | output | 1 | Sticky illegal-command flag |

## Verification
Each command code is driven at least once, with bank select and A10 varied, so that wrong bit positions or swapped banks show up in `cmd_stb` and `bank_active`. Reads are issued at latency 2 and at latency 3, with the mask raised either on the read edge or one edge later. This separates the two-clock read mask from the zero-clock write mask and catches an off-by-one in the latency pipe. Clock-enable low pulses are placed with a bank open, with all banks idle, and together with a refresh. These three cases separate suspend, power-down and self-refresh, and a command driven on the exit edge shows the one-clock exit. Illegal commands are tried from a fresh reset each time, so that each one alone is seen to set the flag and leave the bank state unchanged.

// File: rtl/sdr_cmd_pkg.sv
`timescale 1ns/1ps
package sdr_cmd_pkg;

    typedef enum logic [3:0] {
        C_NOP, C_MRS, C_REF, C_SREF, C_PRE, C_PALL,
        C_ACT, C_WR, C_WRA, C_RD, C_RDA, C_BST
    } cmd_e;

    typedef enum logic [1:0] {
        M_RUN, M_SUSP, M_PDN, M_SREF
    } mode_e;

    typedef enum logic {
        B_IDLE, B_OPEN
    } bank_e;

    localparam int STB_W  = 11;
    localparam int S_MRS  = 0;
    localparam int S_REF  = 1;
    localparam int S_SREF = 2;
    localparam int S_PRE  = 3;
    localparam int S_PALL = 4;
    localparam int S_ACT  = 5;
    localparam int S_WR   = 6;
    localparam int S_WRA  = 7;
    localparam int S_RD   = 8;
    localparam int S_RDA  = 9;
    localparam int S_BST  = 10;

endpackage

// File: rtl/sdr_pin_decode.sv
`timescale 1ns/1ps
module sdr_pin_decode
    import sdr_cmd_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic cke,
    input  logic ap,
    output cmd_e cmd
);

    always_comb begin
        cmd = C_NOP;
        if (!cs_n) begin
            unique case ({ras_n, cas_n, we_n})
                3'b000: cmd = C_MRS;
                3'b001: cmd = cke ? C_REF : C_SREF;
                3'b010: cmd = ap ? C_PALL : C_PRE;
                3'b011: cmd = C_ACT;
                3'b100: cmd = ap ? C_WRA : C_WR;
                3'b101: cmd = ap ? C_RDA : C_RD;
                3'b110: cmd = C_BST;
                3'b111: cmd = C_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdr_power_fsm.sv
`timescale 1ns/1ps
module sdr_power_fsm
    import sdr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cke,
    input  logic sref_go,
    input  logic pd_ok,
    input  logic all_idle,
    output logic run,
    output logic pwr_down
);

    mode_e mode_q, mode_d;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            M_RUN: begin
                if (!cke) begin
                    if (sref_go)    mode_d = M_SREF;
                    else if (pd_ok) mode_d = M_PDN;
                    else            mode_d = M_SUSP;
                end
            end
            M_SUSP, M_PDN, M_SREF: begin
                if (cke) mode_d = M_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= M_RUN;
        else        mode_q <= mode_d;
    end

    always_comb begin
        run      = (mode_q == M_RUN);
        pwr_down = (mode_q == M_PDN) || (mode_q == M_SREF);
    end

    // R7: low-power state is entered only from an all-idle device
    a_r7_pd_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_down) |-> $past(all_idle));

endmodule

// File: rtl/sdr_bank_fsm.sv
`timescale 1ns/1ps
module sdr_bank_fsm
    import sdr_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_go,
    input  logic close_go,
    output logic is_open
);

    bank_e st_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q <= B_IDLE;
        else if (open_go)  st_q <= B_OPEN;
        else if (close_go) st_q <= B_IDLE;
    end

    always_comb is_open = (st_q == B_OPEN);

    a_r2_open_follows: assert property (@(posedge clk) disable iff (!rst_n)
        open_go |=> is_open);
    a_r2_close_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (close_go && !open_go) |=> !is_open);

endmodule

// File: rtl/sdr_dq_path.sv
`timescale 1ns/1ps
module sdr_dq_path #(
    parameter int CL_MAX = 3,
    parameter int CL_W   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            adv,
    input  logic            rd_go,
    input  logic            wr_go,
    input  logic            dqm,
    input  logic [CL_W-1:0] cl,
    output logic            rd_oe,
    output logic            wr_mask
);

    localparam int PIPE_D = CL_MAX - 1;

    logic [PIPE_D-1:0] pipe_q, pipe_d;
    logic              dqm_q;
    logic              due;

    always_comb begin
        due    = pipe_q[0] | (rd_go && int'(cl) == 1);
        pipe_d = pipe_q >> 1;
        for (int i = 0; i < PIPE_D; i++) begin
            if (rd_go && int'(cl) == i + 2) pipe_d[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q  <= '0;
            dqm_q   <= 1'b0;
            rd_oe   <= 1'b0;
            wr_mask <= 1'b0;
        end else begin
            if (adv) begin
                pipe_q <= pipe_d;
                dqm_q  <= dqm;
                rd_oe  <= due & ~dqm_q;
            end
            wr_mask <= wr_go & dqm;
        end
    end

    // R6: a frozen clock holds the read output enable
    a_r6_oe_held: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(rd_oe));

endmodule

// File: rtl/sdr_cmd_ctrl.sv
`timescale 1ns/1ps
module sdr_cmd_ctrl
    import sdr_cmd_pkg::*;
#(
    parameter int ADDR_W   = 11,
    parameter int AP_BIT   = 10,
    parameter int CL_LSB   = 4,
    parameter int CL_MAX   = 3,
    parameter int CL_RESET = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              dqm,
    input  logic              bank_sel,
    input  logic [ADDR_W-1:0] addr,
    output logic [STB_W-1:0]  cmd_stb,
    output logic [1:0]        bank_active,
    output logic              rd_oe,
    output logic              wr_mask,
    output logic              pwr_down,
    output logic              err
);

    localparam int NBANK = 2;
    localparam int CL_W  = $clog2(CL_MAX + 1);

    cmd_e             cmd;
    logic             run, all_idle, tgt_open, legal, acc;
    logic [NBANK-1:0] bank_open, open_go, close_go;
    logic [CL_W-1:0]  cl_q, cl_field;
    logic [STB_W-1:0] stb_d;
    logic             unused_addr;

    assign unused_addr = ^addr;
    assign cl_field    = addr[CL_LSB +: CL_W];

    sdr_pin_decode u_dec (
        .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
        .cke  (cke),  .ap    (addr[AP_BIT]), .cmd (cmd)
    );

    always_comb begin
        all_idle = ~|bank_open;
        tgt_open = bank_open[bank_sel];
        unique case (cmd)
            C_MRS:               legal = all_idle && cl_field != '0
                                         && int'(cl_field) <= CL_MAX;
            C_REF, C_SREF:       legal = all_idle;
            C_ACT:               legal = !tgt_open;
            C_RD, C_RDA,
            C_WR, C_WRA:         legal = tgt_open;
            default:             legal = 1'b1;
        endcase
        acc = run && legal && (cmd != C_NOP);
        for (int b = 0; b < NBANK; b++) begin
            open_go[b]  = acc && cmd == C_ACT && int'(bank_sel) == b;
            close_go[b] = acc && (cmd == C_PALL ||
                          ((cmd == C_PRE || cmd == C_RDA || cmd == C_WRA)
                           && int'(bank_sel) == b));
        end
    end

    always_comb begin
        stb_d = '0;
        if (acc) begin
            unique case (cmd)
                C_MRS:   stb_d[S_MRS]  = 1'b1;
                C_REF:   stb_d[S_REF]  = 1'b1;
                C_SREF:  stb_d[S_SREF] = 1'b1;
                C_PRE:   stb_d[S_PRE]  = 1'b1;
                C_PALL:  stb_d[S_PALL] = 1'b1;
                C_ACT:   stb_d[S_ACT]  = 1'b1;
                C_WR:    stb_d[S_WR]   = 1'b1;
                C_WRA:   stb_d[S_WRA]  = 1'b1;
                C_RD:    stb_d[S_RD]   = 1'b1;
                C_RDA:   stb_d[S_RDA]  = 1'b1;
                C_BST:   stb_d[S_BST]  = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_stb <= '0;
            err     <= 1'b0;
            cl_q    <= CL_W'(CL_RESET);
        end else begin
            cmd_stb <= stb_d;
            if (run && !legal)        err  <= 1'b1;
            if (acc && cmd == C_MRS)  cl_q <= cl_field;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        sdr_bank_fsm u_bank (
            .clk (clk), .rst_n (rst_n),
            .open_go (open_go[b]), .close_go (close_go[b]),
            .is_open (bank_open[b])
        );
    end

    assign bank_active = bank_open;

    sdr_power_fsm u_pwr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke      (cke),
        .sref_go  (acc && cmd == C_SREF),
        .pd_ok    (cmd == C_NOP && all_idle),
        .all_idle (all_idle),
        .run      (run),
        .pwr_down (pwr_down)
    );

    sdr_dq_path #(.CL_MAX (CL_MAX), .CL_W (CL_W)) u_dq (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (run),
        .rd_go   (acc && (cmd == C_RD || cmd == C_RDA)),
        .wr_go   (acc && (cmd == C_WR || cmd == C_WRA)),
        .dqm     (dqm),
        .cl      (cl_q),
        .rd_oe   (rd_oe),
        .wr_mask (wr_mask)
    );

    a_r1_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_stb));
    a_r6_frozen_no_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cmd_stb == '0));
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    a_r3_mask_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |-> (cmd_stb[S_WR] || cmd_stb[S_WRA]));

endmodule

// File: tb/sdr_cmd_ctrl_tb.sv
`timescale 1ns/1ps
module sdr_cmd_ctrl_tb;

    localparam logic [2:0] K_MRS = 3'b000, K_REF = 3'b001, K_PRE = 3'b010,
                           K_ACT = 3'b011, K_WR  = 3'b100, K_RD  = 3'b101,
                           K_BST = 3'b110, K_NOP = 3'b111;
    localparam logic [10:0] AP  = 11'h400;
    localparam logic [10:0] CL3 = 11'h030;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic        dqm = 1'b0, bank_sel = 1'b0;
    logic [10:0] addr = '0;
    logic [10:0] cmd_stb;
    logic [1:0]  bank_active;
    logic        rd_oe, wr_mask, pwr_down, err;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sdr_cmd_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .cke (cke), .cs_n (cs_n),
        .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n), .dqm (dqm),
        .bank_sel (bank_sel), .addr (addr), .cmd_stb (cmd_stb),
        .bank_active (bank_active), .rd_oe (rd_oe), .wr_mask (wr_mask),
        .pwr_down (pwr_down), .err (err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic op(input logic [2:0] code, input logic b, input logic [10:0] a,
                      input logic d, input logic k);
        cke = k; cs_n = 1'b0; {ras_n, cas_n, we_n} = code;
        dqm = d; bank_sel = b; addr = a;
        @(negedge clk);
    endtask

    task automatic nop(input logic k, input logic d);
        op(K_NOP, 1'b0, 11'h000, d, k);
    endtask

    task automatic desel();
        cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = K_NOP; dqm = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        desel();
        desel();
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 stb", int'(cmd_stb), 0);
        chk("R10 banks", int'(bank_active), 0);
        chk("R10 oe/mask", int'({rd_oe, wr_mask}), 0);
        chk("R10 pd/err", int'({pwr_down, err}), 0);
    endtask

    task automatic t_activate();
        op(K_ACT, 1'b0, 11'h123, 1'b0, 1'b1);
        chk("R1 act strobe", int'(cmd_stb), 1 << 5);
        chk("R2 bank0 open", int'(bank_active), 1);
        op(K_ACT, 1'b1, 11'h055, 1'b0, 1'b1);
        chk("R2 bank1 open", int'(bank_active), 3);
    endtask

    task automatic t_write();
        op(K_WR, 1'b0, 11'h010, 1'b1, 1'b1);
        chk("R1 write strobe", int'(cmd_stb), 1 << 6);
        chk("R3 masked write", int'(wr_mask), 1);
        op(K_WR, 1'b0, 11'h011, 1'b0, 1'b1);
        chk("R3 unmasked write", int'(wr_mask), 0);
        op(K_WR, 1'b1, AP, 1'b0, 1'b1);
        chk("R1 write-ap strobe", int'(cmd_stb), 1 << 7);
        chk("R2 write-ap closes bank1", int'(bank_active), 1);
        nop(1'b1, 1'b1);
        chk("R3 mask needs write", int'(wr_mask), 0);
    endtask

    task automatic t_read_cl2();
        op(K_RD, 1'b0, 11'h020, 1'b0, 1'b1);
        chk("R1 read strobe", int'(cmd_stb), 1 << 8);
        chk("R4 cl2 not early", int'(rd_oe), 0);
        nop(1'b1, 1'b0);
        chk("R4 cl2 oe", int'(rd_oe), 1);
        nop(1'b1, 1'b0);
        chk("R4 cl2 oe single", int'(rd_oe), 0);
    endtask

    task automatic t_read_mask();
        op(K_RD, 1'b0, 11'h021, 1'b1, 1'b1);
        nop(1'b1, 1'b0);
        chk("R5 dqm on read edge masks", int'(rd_oe), 0);
        nop(1'b1, 1'b0);
        op(K_RD, 1'b0, 11'h022, 1'b0, 1'b1);
        nop(1'b1, 1'b1);
        chk("R5 late dqm no effect", int'(rd_oe), 1);
        nop(1'b1, 1'b0);
        chk("R5 oe ends", int'(rd_oe), 0);
    endtask

    task automatic t_mode_cl3();
        op(K_PRE, 1'b0, AP, 1'b0, 1'b1);
        chk("R1 precharge-all strobe", int'(cmd_stb), 1 << 4);
        chk("R2 all closed", int'(bank_active), 0);
        op(K_MRS, 1'b0, CL3, 1'b0, 1'b1);
        chk("R1 mode strobe", int'(cmd_stb), 1 << 0);
        op(K_ACT, 1'b0, 11'h001, 1'b0, 1'b1);
        op(K_RD, 1'b0, AP, 1'b0, 1'b1);
        chk("R1 read-ap strobe", int'(cmd_stb), 1 << 9);
        chk("R2 read-ap closes", int'(bank_active), 0);
        nop(1'b1, 1'b0);
        chk("R4 cl3 not at +1", int'(rd_oe), 0);
        nop(1'b1, 1'b0);
        chk("R4 cl3 oe", int'(rd_oe), 1);
        nop(1'b1, 1'b0);
        chk("R4 cl3 single", int'(rd_oe), 0);
    endtask

    task automatic t_suspend();
        op(K_ACT, 1'b0, 11'h002, 1'b0, 1'b1);
        op(K_RD, 1'b0, 11'h003, 1'b0, 1'b1);
        nop(1'b0, 1'b0);
        chk("R6 suspend not powerdown", int'(pwr_down), 0);
        chk("R6 oe before freeze", int'(rd_oe), 0);
        op(K_ACT, 1'b1, 11'h004, 1'b0, 1'b0);
        chk("R6 no strobe frozen", int'(cmd_stb), 0);
        chk("R6 bank kept frozen", int'(bank_active), 1);
        chk("R6 oe stretched", int'(rd_oe), 0);
        nop(1'b1, 1'b0);
        chk("R6 exit edge frozen", int'(rd_oe), 0);
        nop(1'b1, 1'b0);
        chk("R6 oe after resume", int'(rd_oe), 1);
        op(K_PRE, 1'b0, 11'h000, 1'b0, 1'b1);
        chk("R1 precharge strobe", int'(cmd_stb), 1 << 3);
        chk("R2 precharge closes", int'(bank_active), 0);
    endtask

    task automatic t_powerdown();
        nop(1'b0, 1'b0);
        chk("R7 enter", int'(pwr_down), 1);
        op(K_ACT, 1'b0, 11'h005, 1'b0, 1'b0);
        chk("R7 ignored in pd", int'(cmd_stb), 0);
        chk("R7 pd holds", int'(pwr_down), 1);
        op(K_ACT, 1'b0, 11'h005, 1'b0, 1'b1);
        chk("R7 exit edge ignored", int'(cmd_stb), 0);
        chk("R7 exit", int'(pwr_down), 0);
        chk("R7 bank still idle", int'(bank_active), 0);
        op(K_ACT, 1'b0, 11'h005, 1'b0, 1'b1);
        chk("R7 accepted after exit", int'(bank_active), 1);
        op(K_PRE, 1'b0, AP, 1'b0, 1'b1);
    endtask

    task automatic t_selfref();
        op(K_REF, 1'b0, 11'h000, 1'b0, 1'b1);
        chk("R8 refresh strobe", int'(cmd_stb), 1 << 1);
        chk("R8 refresh no pd", int'(pwr_down), 0);
        op(K_REF, 1'b0, 11'h000, 1'b0, 1'b0);
        chk("R8 self refresh strobe", int'(cmd_stb), 1 << 2);
        chk("R8 self refresh pd", int'(pwr_down), 1);
        nop(1'b0, 1'b0);
        chk("R8 stays", int'(pwr_down), 1);
        nop(1'b1, 1'b0);
        chk("R8 exit", int'(pwr_down), 0);
    endtask

    task automatic t_burst();
        op(K_BST, 1'b0, 11'h000, 1'b0, 1'b1);
        chk("R1 burst stop strobe", int'(cmd_stb), 1 << 10);
        desel();
        chk("R1 deselect no strobe", int'(cmd_stb), 0);
        chk("R9 no error so far", int'(err), 0);
    endtask

    task automatic t_err_act();
        do_reset();
        op(K_ACT, 1'b1, 11'h006, 1'b0, 1'b1);
        op(K_ACT, 1'b1, 11'h007, 1'b0, 1'b1);
        chk("R9 double act err", int'(err), 1);
        chk("R9 double act no strobe", int'(cmd_stb), 0);
        chk("R9 double act banks", int'(bank_active), 2);
        nop(1'b1, 1'b0);
        chk("R9 sticky", int'(err), 1);
    endtask

    task automatic t_err_rd();
        do_reset();
        op(K_RD, 1'b0, 11'h008, 1'b0, 1'b1);
        chk("R9 read idle err", int'(err), 1);
        chk("R9 read idle no strobe", int'(cmd_stb), 0);
        nop(1'b1, 1'b0);
        chk("R9 read idle no oe", int'(rd_oe), 0);
    endtask

    task automatic t_err_mrs();
        do_reset();
        op(K_ACT, 1'b0, 11'h009, 1'b0, 1'b1);
        op(K_MRS, 1'b0, CL3, 1'b0, 1'b1);
        chk("R9 mode set busy err", int'(err), 1);
        chk("R9 mode set no strobe", int'(cmd_stb), 0);
        op(K_RD, 1'b0, 11'h00a, 1'b0, 1'b1);
        nop(1'b1, 1'b0);
        chk("R4 latency unchanged by rejected mode set", int'(rd_oe), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R1: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_activate();
        t_write();
        t_read_cl2();
        t_read_mask();
        t_mode_cl3();
        t_suspend();
        t_powerdown();
        t_selfref();
        t_burst();
        t_err_act();
        t_err_rd();
        t_err_mrs();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule